// File: doc/BRIEF.md
# Dual-View Stack Register File

This block holds eight 80-bit registers that software can reach in two ways. In the stack view, a 3-bit top pointer gives each register a name relative to the top. Stack slot `i` is physical entry `(top + i) mod 8`, and slot 0 is the top. A push lowers the pointer and then writes the new top. A pop reads the top and then raises the pointer. Every two-operand stack operation must use slot 0 as one of its operands. An exchange swaps any slot with slot 0, and is the only direct way to reach a deep slot. A constant push loads one of four built-in extended-precision values.

In the flat view the same eight entries are addressed by a fixed, absolute index as 64-bit packed-integer registers. A flat register is the low 64 bits of its entry. Every flat write forces bits 79:64 of the entry to all ones, returns the top pointer to 0 and marks every entry as occupied. A lane-wise add and subtract works on the flat view in 8, 16, 32 or 64-bit lanes.

Each entry carries an occupancy tag. Pushing onto an occupied entry sets a sticky overflow flag. Touching an empty entry from the stack view sets a sticky underflow flag. In both cases the operation leaves the storage unchanged. The block does no floating-point arithmetic: the two stack operands are presented on output taps, and the result comes back on an input port.

Top module: `dualview_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, the top pointer is set to 0, all tags are set empty, both flags are cleared and `rd_valid` is cleared.
- R2: Stack slot i is physical entry (top+i) mod 8. `opa_data` always shows slot 0 and `opb_data` shows slot `op_idx`. A push (code 1) moves the top to top-1, stores `wr_data` there and tags it occupied.
- R3: A pop (code 2) returns slot 0 on `rd_data` with `rd_valid` high one cycle later, tags that entry empty and moves the top to top+1. A peek (code 6) returns slot `op_idx` and leaves the top unchanged.
- R4: The arithmetic write (code 3) stores `arith_res` into slot 0 when `op_dir`=0, or into slot `op_idx` when `op_dir`=1. The top is unchanged.
- R5: An exchange (code 4) swaps the contents of slot `op_idx` and slot 0.
- R6: A constant push (code 5) behaves as a push of a value chosen by `op_idx[1:0]`. The values are 0 → all zero; 1 → 80'h3FFF8000000000000000 (one); 2 → 80'h4000D49A784BCD1B8AFE (log2 10); 3 → 80'h3FFD9A209A84FBCFF799 (log10 2).
- R7: A push or constant push whose target entry is occupied sets the sticky `ovf_flag`. It writes nothing and leaves the top unchanged.
- R8: A pop, peek, arithmetic write or exchange that touches an empty slot sets the sticky `unf_flag`. It changes no data, tag or pointer, and `rd_valid` stays low.
- R9: A clear (code 7) tags all eight entries empty and leaves data and top unchanged.
- R10: A flat write (code 8) stores {16'hFFFF, `wr_data[63:0]`} into entry `op_idx` (absolute), sets the top to 0 and tags all entries occupied.
- R11: A flat read (code 9) returns entry `op_idx` (absolute, all 80 bits), whatever the top and tags are.
- R12: A flat add (code 10) or subtract (code 11) stores {16'hFFFF, low64(entry `op_idx`) ± low64(entry `op_idx2`)} into entry `op_idx`. The lane width comes from `op_lane` (0: 8, 1: 16, 2: 32, 3: 64 bits) and no carry or borrow crosses a lane. The top goes to 0 and all entries are tagged occupied.
- R13: One operation is taken per clock and only while `op_valid` is high. With `op_valid` low, or with codes 0 and 12-15, nothing changes and `rd_valid` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code |
| op_idx | input | 3 | Stack slot, flat index or constant select |
| op_idx2 | input | 3 | Second flat index for lane add/subtract |
| op_dir | input | 1 | Arithmetic destination: 0 slot 0, 1 slot `op_idx` |
| op_lane | input | 2 | Lane width select |
| wr_data | input | 80 | Push / flat write data |
| arith_res | input | 80 | External arithmetic result |
| opa_data | output | 80 | Slot 0 contents |
| opb_data | output | 80 | Slot `op_idx` contents |
| rd_data | output | 80 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| stack_top | output | 3 | Current top pointer |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |

## Verification
The bench goes after pointer wrap: filling all eight slots and pushing a ninth must raise overflow without moving the top. A design that wraps mod the wrong value, or writes before it checks the tag, would overwrite the bottom entry. It aims lane add and subtract at operands whose bytes sit at 0xFF and 0x00, so that carries and borrows try to cross every lane boundary. A leaky carry chain would corrupt the neighbouring lane in the narrow modes. It also mixes flat writes into stack traffic: a design that did not reset the top, re-tag the entries or force the upper 16 bits would return wrong pops, false overflows or wrong exponent bits. Random mixed traffic then follows the reference model on every clock.

// File: rtl/dvrf_pkg.sv
package dvrf_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_PUSH  = 4'd1,
    OP_POP   = 4'd2,
    OP_ARITH = 4'd3,
    OP_XCHG  = 4'd4,
    OP_PUSHK = 4'd5,
    OP_PEEK  = 4'd6,
    OP_CLEAR = 4'd7,
    OP_FWR   = 4'd8,
    OP_FRD   = 4'd9,
    OP_FADD  = 4'd10,
    OP_FSUB  = 4'd11
  } op_e;
endpackage

// File: rtl/dvrf_const_rom.sv
module dvrf_const_rom #(
  parameter int ENTRY_W = 80
) (
  input  logic [1:0]         sel,
  output logic [ENTRY_W-1:0] value
);
  // R6: extended-precision constants, sign|exponent(15)|mantissa(64)
  always_comb begin
    case (sel)
      2'd1:    value = ENTRY_W'(80'h3FFF_8000_0000_0000_0000);
      2'd2:    value = ENTRY_W'(80'h4000_D49A_784B_CD1B_8AFE);
      2'd3:    value = ENTRY_W'(80'h3FFD_9A20_9A84_FBCF_F799);
      default: value = '0;
    endcase
  end
endmodule

// File: rtl/dvrf_lane_alu.sv
module dvrf_lane_alu #(
  parameter int DATA_W = 64,
  parameter int SEL_W  = 2
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic [SEL_W-1:0]  lane_sel,
  output logic [DATA_W-1:0] res
);
  localparam int NB = DATA_W / 8;

  logic [NB:0]   cy;
  logic [NB-1:0] bnd;
  logic [7:0]    lmask;

  assign lmask = (8'd1 << lane_sel) - 8'd1;
  assign cy[0] = sub;

  genvar k;
  generate
    for (k = 0; k < NB; k++) begin : g_byte
      logic [8:0] s;
      logic       cin;
      assign bnd[k]   = ((8'(k) & lmask) == 8'd0);
      assign cin      = bnd[k] ? sub : cy[k];
      assign s        = {1'b0, a[8*k +: 8]} + {1'b0, b[8*k +: 8] ^ {8{sub}}} + {8'd0, cin};
      assign res[8*k +: 8] = s[7:0];
      assign cy[k+1]  = s[8];
    end
  endgenerate

  // R12
  always_comb begin
    if (DATA_W == 64 && lane_sel == SEL_W'(3) && !sub && !$isunknown(a) && !$isunknown(b))
      lane64_add_chk: assert (res == a + b);
  end
endmodule

// File: rtl/dualview_regfile.sv
module dualview_regfile
  import dvrf_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ENTRY_W = 80,
  parameter int FLAT_W  = 64,
  parameter int IDX_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  input  logic [3:0]         op_code,
  input  logic [IDX_W-1:0]   op_idx,
  input  logic [IDX_W-1:0]   op_idx2,
  input  logic               op_dir,
  input  logic [1:0]         op_lane,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [ENTRY_W-1:0] arith_res,
  output logic [ENTRY_W-1:0] opa_data,
  output logic [ENTRY_W-1:0] opb_data,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               rd_valid,
  output logic [IDX_W-1:0]   stack_top,
  output logic               ovf_flag,
  output logic               unf_flag
);
  localparam int HI_W = ENTRY_W - FLAT_W;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]   tag_q, tag_nx;
  logic [IDX_W-1:0]   top_q, top_nx;
  logic               ovf_q, unf_q, ovf_set, unf_set;
  logic               rd_ld;
  logic [ENTRY_W-1:0] rd_nx;

  logic [IDX_W-1:0]   p0, pi, pdn;
  logic               we0, we1;
  logic [IDX_W-1:0]   wa0, wa1;
  logic [ENTRY_W-1:0] wd0, wd1;
  logic [ENTRY_W-1:0] kval;
  logic [FLAT_W-1:0]  alu_res;

  assign p0  = top_q;
  assign pi  = top_q + op_idx;
  assign pdn = top_q - 1'b1;

  assign opa_data  = mem[p0];
  assign opb_data  = mem[pi];
  assign stack_top = top_q;
  assign ovf_flag  = ovf_q;
  assign unf_flag  = unf_q;

  dvrf_const_rom #(.ENTRY_W(ENTRY_W)) u_rom (
    .sel   (op_idx[1:0]),
    .value (kval)
  );

  dvrf_lane_alu #(.DATA_W(FLAT_W), .SEL_W(2)) u_alu (
    .a        (mem[op_idx][FLAT_W-1:0]),
    .b        (mem[op_idx2][FLAT_W-1:0]),
    .sub      (op_code == OP_FSUB),
    .lane_sel (op_lane),
    .res      (alu_res)
  );

  // Decode: one operation per clock, at most two entry writes (exchange)
  always_comb begin
    we0 = 1'b0;  wa0 = p0;  wd0 = wr_data;
    we1 = 1'b0;  wa1 = pi;  wd1 = mem[p0];
    top_nx  = top_q;
    tag_nx  = tag_q;
    ovf_set = 1'b0;
    unf_set = 1'b0;
    rd_ld   = 1'b0;
    rd_nx   = mem[p0];
    if (op_valid) begin
      case (op_code)
        OP_PUSH, OP_PUSHK: begin
          if (tag_q[pdn]) ovf_set = 1'b1;
          else begin
            we0 = 1'b1;
            wa0 = pdn;
            wd0 = (op_code == OP_PUSH) ? wr_data : kval;
            top_nx = pdn;
            tag_nx[pdn] = 1'b1;
          end
        end
        OP_POP: begin
          if (!tag_q[p0]) unf_set = 1'b1;
          else begin
            rd_ld = 1'b1;
            tag_nx[p0] = 1'b0;
            top_nx = top_q + 1'b1;
          end
        end
        OP_PEEK: begin
          if (!tag_q[pi]) unf_set = 1'b1;
          else begin
            rd_ld = 1'b1;
            rd_nx = mem[pi];
          end
        end
        OP_ARITH: begin
          if (!tag_q[p0] || !tag_q[pi]) unf_set = 1'b1;
          else begin
            we0 = 1'b1;
            wa0 = op_dir ? pi : p0;
            wd0 = arith_res;
          end
        end
        OP_XCHG: begin
          if (!tag_q[p0] || !tag_q[pi]) unf_set = 1'b1;
          else begin
            we0 = 1'b1;
            wa0 = p0;
            wd0 = mem[pi];
            we1 = 1'b1;
          end
        end
        OP_CLEAR: tag_nx = '0;
        OP_FWR, OP_FADD, OP_FSUB: begin
          we0 = 1'b1;
          wa0 = op_idx;
          wd0 = {{HI_W{1'b1}}, (op_code == OP_FWR) ? wr_data[FLAT_W-1:0] : alu_res};
          top_nx = '0;
          tag_nx = '1;
        end
        OP_FRD: begin
          rd_ld = 1'b1;
          rd_nx = mem[op_idx];
        end
        default: ;
      endcase
    end
  end

  // Storage: no reset, plain write ports
  always_ff @(posedge clk) begin
    if (we0) mem[wa0] <= wd0;
    if (we1) mem[wa1] <= wd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q    <= '0;
      tag_q    <= '0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      top_q    <= top_nx;
      tag_q    <= tag_nx;
      ovf_q    <= ovf_q | ovf_set;
      unf_q    <= unf_q | unf_set;
      rd_valid <= rd_ld;
      if (rd_ld) rd_data <= rd_nx;
    end
  end

  // R2
  push_move_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_PUSH && !tag_q[pdn]) |=>
      (stack_top == IDX_W'($past(stack_top) - 1'b1)) && tag_q[stack_top]);

  // R3
  pop_move_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_POP && tag_q[top_q]) |=>
      rd_valid && (stack_top == IDX_W'($past(stack_top) + 1'b1)));

  // R7
  no_overflow_move_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_PUSH || op_code == OP_PUSHK) && tag_q[pdn]) |=>
      $stable(stack_top) && ovf_flag);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  // R8
  unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    unf_flag |=> unf_flag);

  // R8
  unf_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_POP && !tag_q[top_q]) |=> !rd_valid && $stable(stack_top));

  // R10
  flat_top_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_FWR || op_code == OP_FADD || op_code == OP_FSUB)) |=>
      (stack_top == '0) && (tag_q == '1));

  // R13
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !rd_valid && $stable(stack_top) && $stable(ovf_flag) && $stable(unf_flag));
endmodule

// File: tb/tb_dualview_regfile.sv
module tb_dualview_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [2:0]  op_idx, op_idx2;
  logic        op_dir;
  logic [1:0]  op_lane;
  logic [79:0] wr_data, arith_res;
  logic [79:0] opa_data, opb_data, rd_data;
  logic        rd_valid, ovf_flag, unf_flag;
  logic [2:0]  stack_top;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dualview_regfile dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_idx(op_idx), .op_idx2(op_idx2), .op_dir(op_dir), .op_lane(op_lane),
    .wr_data(wr_data), .arith_res(arith_res), .opa_data(opa_data),
    .opb_data(opb_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .stack_top(stack_top), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  // Reference model state
  logic [79:0] m_mem [8];
  bit          m_tag [8];
  int          m_top;
  bit          m_ovf, m_unf, m_rdv;
  logic [79:0] m_rdd;

  task automatic chk(input string req, input string what, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input bit v, input int op);
    if (!v) return "R13";
    case (op)
      1: return "R2";  2: return "R3";  3: return "R4";  4: return "R5";
      5: return "R6";  6: return "R3";  7: return "R9";  8: return "R10";
      9: return "R11"; 10, 11: return "R12";
      default: return "R13";
    endcase
  endfunction

  function automatic logic [79:0] kval(input int s);
    case (s)
      1: return 80'h3FFF8000000000000000;
      2: return 80'h4000D49A784BCD1B8AFE;
      3: return 80'h3FFD9A209A84FBCFF799;
      default: return 80'h0;
    endcase
  endfunction

  function automatic logic [63:0] lanes(input logic [63:0] a, input logic [63:0] b, input int lane, input bit sub);
    int w = 8 << lane;
    logic [63:0] m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    logic [63:0] r = 64'd0;
    for (int l = 0; l < 64 / w; l++) begin
      logic [63:0] x = (a >> (l * w)) & m;
      logic [63:0] y = (b >> (l * w)) & m;
      logic [63:0] z = (sub ? x - y : x + y) & m;
      r = r | (z << (l * w));
    end
    return r;
  endfunction

  task automatic model_step(input bit v, input int op, input int idx, input int idx2,
                            input bit dir, input int lane, input logic [79:0] wd, input logic [79:0] ar);
    int p0 = m_top;
    int pi = (m_top + idx) % 8;
    int pd = (m_top + 7) % 8;
    logic [79:0] t;
    m_rdv = 0;
    if (!v) return;
    case (op)
      1, 5: begin
        if (m_tag[pd]) m_ovf = 1;
        else begin
          m_mem[pd] = (op == 1) ? wd : kval(idx % 4);
          m_tag[pd] = 1; m_top = pd;
        end
      end
      2: if (!m_tag[p0]) m_unf = 1;
         else begin m_rdv = 1; m_rdd = m_mem[p0]; m_tag[p0] = 0; m_top = (m_top + 1) % 8; end
      6: if (!m_tag[pi]) m_unf = 1;
         else begin m_rdv = 1; m_rdd = m_mem[pi]; end
      3: if (!m_tag[p0] || !m_tag[pi]) m_unf = 1;
         else if (dir) m_mem[pi] = ar; else m_mem[p0] = ar;
      4: if (!m_tag[p0] || !m_tag[pi]) m_unf = 1;
         else begin t = m_mem[p0]; m_mem[p0] = m_mem[pi]; m_mem[pi] = t; end
      7: for (int i = 0; i < 8; i++) m_tag[i] = 0;
      8, 10, 11: begin
        if (op == 8) m_mem[idx] = {16'hFFFF, wd[63:0]};
        else m_mem[idx] = {16'hFFFF, lanes(m_mem[idx][63:0], m_mem[idx2][63:0], lane, op == 11)};
        m_top = 0;
        for (int i = 0; i < 8; i++) m_tag[i] = 1;
      end
      9: begin m_rdv = 1; m_rdd = m_mem[idx]; end
      default: ;
    endcase
  endtask

  task automatic do_op(input bit v, input int op, input int idx, input int idx2 = 0,
                       input bit dir = 0, input int lane = 0,
                       input logic [79:0] wd = '0, input logic [79:0] ar = '0);
    string rq = req_of(v, op);
    @(negedge clk);
    op_valid = v; op_code = 4'(op); op_idx = 3'(idx); op_idx2 = 3'(idx2);
    op_dir = dir; op_lane = 2'(lane); wr_data = wd; arith_res = ar;
    #1;
    if (!$isunknown(m_mem[m_top])) chk("R2", "opa_data", opa_data, m_mem[m_top]);
    if (!$isunknown(m_mem[(m_top + idx) % 8])) chk("R2", "opb_data", opb_data, m_mem[(m_top + idx) % 8]);
    model_step(v, op, idx, idx2, dir, lane, wd, ar);
    @(negedge clk);
    op_valid = 0;
    chk(rq, "rd_valid", {79'd0, rd_valid}, {79'd0, m_rdv});
    if (m_rdv && !$isunknown(m_rdd)) chk(rq, "rd_data", rd_data, m_rdd);
    chk(rq, "stack_top", {77'd0, stack_top}, 80'(m_top));
    chk(rq, "ovf_flag", {79'd0, ovf_flag}, {79'd0, m_ovf});
    chk(rq, "unf_flag", {79'd0, unf_flag}, {79'd0, m_unf});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; op_valid = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    m_top = 0; m_ovf = 0; m_unf = 0; m_rdv = 0;
    for (int i = 0; i < 8; i++) m_tag[i] = 0;
    chk("R1", "stack_top", {77'd0, stack_top}, 80'd0);
    chk("R1", "ovf_flag", {79'd0, ovf_flag}, 80'd0);
    chk("R1", "unf_flag", {79'd0, unf_flag}, 80'd0);
    chk("R1", "rd_valid", {79'd0, rd_valid}, 80'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; op_valid = 0; op_code = 0; op_idx = 0; op_idx2 = 0;
    op_dir = 0; op_lane = 0; wr_data = '0; arith_res = '0;
    for (int i = 0; i < 8; i++) m_mem[i] = 'x;
    do_reset();

    // R8: pop and peek of empty stack
    do_op(1, 2, 0);
    do_op(1, 6, 3);
    do_reset();

    // R2 / R3: pushes, peeks, wrap of top below 0
    do_op(1, 1, 0, 0, 0, 0, 80'h1111_0000_0000_0000_00AA);
    do_op(1, 1, 0, 0, 0, 0, 80'h2222_0000_0000_0000_00BB);
    do_op(1, 1, 0, 0, 0, 0, 80'h3333_0000_0000_0000_00CC);
    chk("R2", "top after 3 pushes", {77'd0, stack_top}, 80'd5);
    do_op(1, 6, 1);
    do_op(1, 6, 2);
    // R5: exchange slot 2 with slot 0
    do_op(1, 4, 2);
    do_op(1, 6, 0);
    chk("R5", "slot0 after xchg", rd_data, 80'h1111_0000_0000_0000_00AA);
    // R4: arithmetic writes both directions
    do_op(1, 3, 1, 0, 0, 0, '0, 80'h4444_5555_6666_7777_8888);
    do_op(1, 3, 2, 0, 1, 0, '0, 80'h9999_AAAA_BBBB_CCCC_DDDD);
    do_op(1, 6, 2);
    // R8: arith touching empty slot 4
    do_op(1, 3, 4, 0, 1, 0, '0, 80'h1);
    do_op(1, 2, 0);
    do_op(1, 2, 0);
    do_op(1, 2, 0);
    do_reset();

    // R6: each constant pushed and popped
    for (int s = 0; s < 4; s++) begin
      do_op(1, 5, s);
      do_op(1, 2, 0);
      chk("R6", "constant", rd_data, kval(s));
    end
    chk("R6", "log2(10) bits", kval(2), 80'h4000D49A784BCD1B8AFE);

    // R7: fill all eight, then overflow
    for (int i = 0; i < 8; i++) do_op(1, 1, 0, 0, 0, 0, 80'(64'hA5A5_0000_0000_0000 + i));
    do_op(1, 1, 0, 0, 0, 0, 80'hDEAD);
    do_op(1, 5, 1);
    do_op(1, 6, 7);
    // R13: not valid, and unused code
    do_op(0, 2, 0);
    do_op(1, 13, 0);
    // R9: clear then underflow
    do_op(1, 7, 0);
    do_op(1, 2, 0);
    do_reset();

    // R10 / R11: flat writes at absolute indices after a push
    do_op(1, 1, 0, 0, 0, 0, 80'h7777);
    do_op(1, 8, 3, 0, 0, 0, 80'h0123_89AB_CDEF_0011_2233);
    do_op(1, 9, 3);
    chk("R10", "upper ones", {64'd0, rd_data[79:64]}, 80'hFFFF);
    do_op(1, 6, 3);
    do_op(1, 1, 0, 0, 0, 0, 80'h1);
    for (int i = 0; i < 8; i++) do_op(1, 8, i, 0, 0, 0, 80'(64'h0102_0304_0506_0708 * (i + 1)));
    do_op(1, 8, 0, 0, 0, 0, 80'h80FF_7FFF_FFFF_00FF);
    do_op(1, 8, 1, 0, 0, 0, 80'h8001_0001_0001_0101);
    // R12: lane modes, add and sub
    for (int ln = 0; ln < 4; ln++) begin
      do_op(1, 10, 2, 0, 0, ln);
      do_op(1, 9, 2);
      do_op(1, 11, 3, 1, 0, ln);
      do_op(1, 9, 3);
    end
    do_op(1, 8, 4, 0, 0, 0, 80'h00FF_00FF_00FF_00FF);
    do_op(1, 8, 5, 0, 0, 0, 80'h0001_0001_0001_0001);
    do_op(1, 10, 4, 5, 0, 0);
    do_op(1, 9, 4);
    chk("R12", "byte lanes no carry", rd_data, 80'hFFFF_0000_0000_0000_0000);
    do_op(1, 2, 0);
    do_op(1, 2, 0);

    // Mixed random traffic against the model
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 13);
      do_op($urandom_range(0, 7) != 0, op, $urandom_range(0, 7), $urandom_range(0, 7),
            1'($urandom_range(0, 1)), $urandom_range(0, 3),
            {$urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule